// File: doc/BRIEF.md
# Two-Wire Register Target with Pointer Auto-Increment

This block is a 7-bit-address target on a two-wire (I2C) bus. It gives a bus master access to a small bank of 8-bit registers. The registers are three sensor sample words, an identity byte, a self-test response byte and five configuration bytes. The block runs entirely in its own system clock. SCL and SDA are synchronised and edge-detected in that clock. The block answers only by pulling SDA low, as an open-drain device does.

A master first writes a register pointer byte. It can then keep writing data bytes, or issue a repeated start and read back. The pointer advances by one after every data byte in either direction, so several neighbouring registers move in one transfer. One slave-address bit comes from a strap input, which lets two targets share a bus. Setting the run bit freezes the configuration bytes. A self-test request shows up as an alternate response byte that a single read returns to normal.

Top module: `i2ct_top`

## Requirements
- R1: The target acknowledges only the slave address 0b000111X, where X is the `addr_sel` input. A byte with any other address gets no acknowledge, and the writes that follow it in that transfer change nothing.
- R2: In a write transfer (start, address with R/W=0, pointer byte, data bytes, stop), every byte is acknowledged by pulling SDA low during the ninth SCL pulse. Each data byte is stored in the register the pointer selects.
- R3: During a burst write, the pointer increments after each data byte, so consecutive data bytes land in consecutive registers.
- R4: A read uses a pointer write, then a repeated start and the address with R/W=1. Data is returned MSB first, 8 bits per byte, with the pointer advancing per byte. A master ACK asks for the next byte, and a master NACK ends the transfer.
- R5: Address 0x09 always reads 0x13, and writes to it are ignored.
- R6: Address 0x08 reads 0x55 while self-test request bit 4 of the second control byte (0x11) is clear, and 0xAA while it is set. Reading 0x08 clears the bit, so the next read returns 0x55.
- R7: While run bit 7 of the first control byte (0x10) is 1, writes to 0x11–0x14 and to bits 6:0 of 0x10 are ignored. Bit 7 stays writable. `run_en` mirrors that bit.
- R8: Addresses with no register read 0x00 and ignore writes, yet their data bytes are still acknowledged.
- R9: After reset, 0x10=0x00, 0x11=0x00, 0x12=0x10, 0x13=0x3F and 0x14=0x02. `run_en` is 0 and SDA is released.
- R10: Addresses 0x00–0x05 hold axes 0, 1 and 2 as low byte then high byte. Each signed sample is left-justified into 16 bits, with the unused low bits read as 0.
- R11: The target changes its SDA drive only while SCL is low, and never drives SDA while the bus is idle.
- R12: The pointer wraps from 0xFF to 0x00 during a burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel | input | 1 | Strap selecting the lowest slave-address bit |
| axis_data | input | AXES*SAMPLE_W | Signed sample words, axis 0 in the low slice |
| sda_pull_low | output | 1 | 1 pulls SDA low; 0 releases it |
| run_en | output | 1 | Current run bit of control byte 0x10 |

## Verification
On every cycle the bound checker enforces several rules. SDA drive may change only after SCL was seen low, and is released in the idle phase. A register strike and a read fetch never happen in the same cycle. Each of them moves the pointer by exactly one. The run bit can rise only through a write to 0x10. The remaining behaviour needs whole bus transfers from the bench and cannot be seen in a single cycle. That covers address filtering by strap, the write protection, the self-test toggle and its clear-on-read, the sample byte packing and the pointer wrap.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int BYTE_W = 8;

    localparam logic [5:0] DEV_ADDR_HI = 6'b000111;

    localparam logic [7:0] A_SELFTEST = 8'h08;
    localparam logic [7:0] A_IDENT    = 8'h09;
    localparam logic [7:0] A_CTRL1    = 8'h10;
    localparam logic [7:0] A_CTRL2    = 8'h11;
    localparam logic [7:0] A_INTCFG   = 8'h12;
    localparam logic [7:0] A_INTMSK   = 8'h13;
    localparam logic [7:0] A_DATCFG   = 8'h14;

    localparam logic [7:0] IDENT_VAL  = 8'h13;
    localparam logic [7:0] ST_NORMAL  = 8'h55;
    localparam logic [7:0] ST_ACTIVE  = 8'hAA;

    localparam logic [7:0] RST_CTRL1  = 8'h00;
    localparam logic [7:0] RST_CTRL2  = 8'h00;
    localparam logic [7:0] RST_INTCFG = 8'h10;
    localparam logic [7:0] RST_INTMSK = 8'h3F;
    localparam logic [7:0] RST_DATCFG = 8'h02;

    localparam int RUN_BIT    = 7;
    localparam int ST_CMD_BIT = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEVADR,
        PH_REGPTR,
        PH_WRDATA,
        PH_RDDATA
    } phase_t;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] b, input logic sel);
        return b[7:1] == {DEV_ADDR_HI, sel};
    endfunction

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync
    import i2ct_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    scl_lvl,
    output bus_ev_t ev
);
    localparam int MSB = STAGES - 1;

    logic [MSB:0] scl_sh, sda_sh;
    logic         scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[MSB-1:0], scl_i};
            sda_sh <= {sda_sh[MSB-1:0], sda_i};
            scl_d  <= scl_sh[MSB];
            sda_d  <= sda_sh[MSB];
        end
    end

    assign scl_lvl = scl_sh[MSB];

    always_comb begin
        ev.sda      = sda_sh[MSB];
        ev.scl_rise = scl_sh[MSB] & ~scl_d;
        ev.scl_fall = ~scl_sh[MSB] & scl_d;
        ev.start    = scl_sh[MSB] & scl_d & sda_d & ~sda_sh[MSB];
        ev.stop     = scl_sh[MSB] & scl_d & ~sda_d & sda_sh[MSB];
    end

endmodule

// File: rtl/i2ct_link.sv
module i2ct_link
    import i2ct_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic       addr_sel,
    input  logic [7:0] rd_data,
    output logic       sda_pull_low,
    output logic       wr_en,
    output logic       rd_en,
    output logic [7:0] reg_ptr,
    output logic [7:0] wr_data,
    output phase_t     ph
);
    logic [3:0] cnt;
    logic [7:0] sh;
    logic       in_ack;
    logic       rnw;
    logic       more;
    logic       byte_done;

    assign byte_done = ev.scl_fall && !in_ack && (cnt == 4'd8);
    assign wr_en     = byte_done && (ph == PH_WRDATA);
    assign rd_en     = ev.scl_fall &&
                       ((in_ack && ph == PH_DEVADR && rnw) ||
                        (!in_ack && ph == PH_RDDATA && cnt == 4'd9 && more));
    assign wr_data   = sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph           <= PH_IDLE;
            cnt          <= '0;
            sh           <= '0;
            in_ack       <= 1'b0;
            rnw          <= 1'b0;
            more         <= 1'b0;
            sda_pull_low <= 1'b0;
            reg_ptr      <= '0;
        end else if (ev.start) begin
            ph           <= PH_DEVADR;
            cnt          <= '0;
            in_ack       <= 1'b0;
            sda_pull_low <= 1'b0;
        end else if (ev.stop) begin
            ph           <= PH_IDLE;
            in_ack       <= 1'b0;
            sda_pull_low <= 1'b0;
        end else begin
            if (ev.scl_rise) begin
                if (ph == PH_RDDATA) begin
                    cnt <= cnt + 4'd1;
                    if (cnt == 4'd8) more <= ~ev.sda;
                end else if (ph != PH_IDLE && !in_ack) begin
                    sh  <= {sh[6:0], ev.sda};
                    cnt <= cnt + 4'd1;
                end
            end
            if (ev.scl_fall) begin
                if (in_ack) begin
                    in_ack       <= 1'b0;
                    sda_pull_low <= 1'b0;
                    cnt          <= '0;
                    case (ph)
                        PH_DEVADR: begin
                            if (rnw) begin
                                ph           <= PH_RDDATA;
                                sh           <= rd_data;
                                sda_pull_low <= ~rd_data[7];
                                reg_ptr      <= reg_ptr + 8'd1;
                            end else begin
                                ph <= PH_REGPTR;
                            end
                        end
                        PH_REGPTR: ph <= PH_WRDATA;
                        default: ;
                    endcase
                end else if (ph == PH_RDDATA) begin
                    if (cnt < 4'd8) begin
                        sh           <= {sh[6:0], 1'b0};
                        sda_pull_low <= ~sh[6];
                    end else if (cnt == 4'd8) begin
                        sda_pull_low <= 1'b0;
                    end else if (more) begin
                        sh           <= rd_data;
                        sda_pull_low <= ~rd_data[7];
                        reg_ptr      <= reg_ptr + 8'd1;
                        cnt          <= '0;
                    end else begin
                        ph <= PH_IDLE;
                    end
                end else if (byte_done) begin
                    case (ph)
                        PH_DEVADR: begin
                            if (dev_match(sh, addr_sel)) begin
                                in_ack       <= 1'b1;
                                sda_pull_low <= 1'b1;
                                rnw          <= sh[0];
                            end else begin
                                ph <= PH_IDLE;
                            end
                        end
                        PH_REGPTR: begin
                            reg_ptr      <= sh;
                            in_ack       <= 1'b1;
                            sda_pull_low <= 1'b1;
                        end
                        PH_WRDATA: begin
                            reg_ptr      <= reg_ptr + 8'd1;
                            in_ack       <= 1'b1;
                            sda_pull_low <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs
    import i2ct_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int AXES     = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [7:0]                    addr,
    input  logic [7:0]                    wdata,
    input  logic [AXES-1:0][SAMPLE_W-1:0] axis_data,
    output logic [7:0]                    rd_data,
    output logic                          run_en
);
    localparam int PAD = 16 - SAMPLE_W;

    logic [7:0] ctrl1, ctrl2, intcfg, intmsk, datcfg;
    logic [AXES-1:0][15:0] axis16;

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        assign axis16[g] = 16'(axis_data[g]) << PAD;
    end

    assign run_en = ctrl1[RUN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl1  <= RST_CTRL1;
            ctrl2  <= RST_CTRL2;
            intcfg <= RST_INTCFG;
            intmsk <= RST_INTMSK;
            datcfg <= RST_DATCFG;
        end else if (wr_en) begin
            case (addr)
                A_CTRL1:  ctrl1 <= run_en ? {wdata[RUN_BIT], ctrl1[RUN_BIT-1:0]} : wdata;
                A_CTRL2:  if (!run_en) ctrl2  <= wdata;
                A_INTCFG: if (!run_en) intcfg <= wdata;
                A_INTMSK: if (!run_en) intmsk <= wdata;
                A_DATCFG: if (!run_en) datcfg <= wdata;
                default: ;
            endcase
        end else if (rd_en && addr == A_SELFTEST) begin
            ctrl2[ST_CMD_BIT] <= 1'b0;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        case (addr)
            A_SELFTEST: rd_data = ctrl2[ST_CMD_BIT] ? ST_ACTIVE : ST_NORMAL;
            A_IDENT:    rd_data = IDENT_VAL;
            A_CTRL1:    rd_data = ctrl1;
            A_CTRL2:    rd_data = ctrl2;
            A_INTCFG:   rd_data = intcfg;
            A_INTMSK:   rd_data = intmsk;
            A_DATCFG:   rd_data = datcfg;
            default: begin
                for (int g = 0; g < AXES; g++) begin
                    if (addr == 8'(2 * g))     rd_data = axis16[g][7:0];
                    if (addr == 8'(2 * g + 1)) rd_data = axis16[g][15:8];
                end
            end
        endcase
    end

endmodule

// File: rtl/i2ct_top.sv
module i2ct_top
    import i2ct_pkg::*;
#(
    parameter int SAMPLE_W    = 12,
    parameter int AXES        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          scl_i,
    input  logic                          sda_i,
    input  logic                          addr_sel,
    input  logic [AXES-1:0][SAMPLE_W-1:0] axis_data,
    output logic                          sda_pull_low,
    output logic                          run_en
);
    bus_ev_t    ev;
    logic       scl_lvl;
    logic       wr_en, rd_en;
    logic [7:0] reg_ptr, wr_data, rd_data;
    phase_t     ph;

    i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_lvl (scl_lvl),
        .ev      (ev)
    );

    i2ct_link u_link (
        .clk          (clk),
        .rst          (rst),
        .ev           (ev),
        .addr_sel     (addr_sel),
        .rd_data      (rd_data),
        .sda_pull_low (sda_pull_low),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .reg_ptr      (reg_ptr),
        .wr_data      (wr_data),
        .ph           (ph)
    );

    i2ct_regs #(.SAMPLE_W(SAMPLE_W), .AXES(AXES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (reg_ptr),
        .wdata     (wr_data),
        .axis_data (axis_data),
        .rd_data   (rd_data),
        .run_en    (run_en)
    );

endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk
    import i2ct_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_lvl,
    input logic       sda_pull_low,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] reg_ptr,
    input phase_t     ph,
    input logic       run_en
);
    // R11: drive edges follow an observed SCL low level
    p_sda_moves_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_low) |-> !$past(scl_lvl));

    // R11: released while the bus is idle
    p_idle_released_r11: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE) |-> !sda_pull_low);

    // R2: a store and a fetch never share a cycle
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rd_en));

    // R3: pointer steps by one after each stored byte
    p_ptr_after_write_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> reg_ptr == $past(reg_ptr) + 8'd1);

    // R4: pointer steps by one after each fetched byte
    p_ptr_after_read_r4: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> reg_ptr == $past(reg_ptr) + 8'd1);

    // R7: run bit rises only through a store to control byte 0x10
    p_run_by_write_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(run_en) |-> $past(wr_en && reg_ptr == A_CTRL1));

endmodule

bind i2ct_top i2ct_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_lvl      (scl_lvl),
    .sda_pull_low (sda_pull_low),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .reg_ptr      (reg_ptr),
    .ph           (ph),
    .run_en       (run_en)
);

// File: tb/i2ct_top_tb.sv
module i2ct_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HP  = 12;
    localparam int SW  = 12;
    localparam int AX  = 3;
    localparam int NV  = 8;

    typedef struct packed {
        logic [7:0] ptr;
        logic [7:0] wval;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    // R2 entries 0-4, R5 entry 5, R8 entry 6, R6 entry 7
    localparam vec_t VECS [NV] = '{
        '{8'h11, 8'h0F, 8'h0F, 4'd2},
        '{8'h12, 8'hA5, 8'hA5, 4'd2},
        '{8'h13, 8'h3C, 8'h3C, 4'd2},
        '{8'h14, 8'h07, 8'h07, 4'd2},
        '{8'h10, 8'h5A, 8'h5A, 4'd2},
        '{8'h09, 8'hFF, 8'h13, 4'd5},
        '{8'h30, 8'h77, 8'h00, 4'd8},
        '{8'h08, 8'h00, 8'h55, 4'd6}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic addr_sel = 1'b0;
    logic [AX-1:0][SW-1:0] axis_data = '0;
    logic sda_pull_low, run_en;
    logic sda_line;
    logic prev_drv = 1'b0;
    logic done = 1'b0;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   drv_violations = 0;

    assign sda_line = m_sda & ~sda_pull_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2ct_top u_dut (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (m_scl),
        .sda_i        (sda_line),
        .addr_sel     (addr_sel),
        .axis_data    (axis_data),
        .sda_pull_low (sda_pull_low),
        .run_en       (run_en)
    );

    // R11 monitor: drive must not move while SCL is high
    always @(negedge clk) begin
        if (!rst && sda_pull_low != prev_drv && m_scl) drv_violations++;
        prev_drv <= sda_pull_low;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(HP);
        m_scl = 1'b1; tick(HP);
        m_sda = 1'b0; tick(HP);
        m_scl = 1'b0; tick(3);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(HP);
        m_scl = 1'b1; tick(HP);
        m_sda = 1'b1; tick(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(HP);
            m_scl = 1'b1; tick(HP);
            m_scl = 1'b0; tick(3);
        end
        m_sda = 1'b1; tick(HP);
        m_scl = 1'b1; tick(HP/2);
        ack = ~sda_line;
        tick(HP/2);
        m_scl = 1'b0; tick(3);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(HP);
            m_scl = 1'b1; tick(HP/2);
            b[i] = sda_line;
            tick(HP/2);
            m_scl = 1'b0; tick(3);
        end
        m_sda = give_ack ? 1'b0 : 1'b1; tick(HP);
        m_scl = 1'b1; tick(HP);
        m_scl = 1'b0; tick(3);
    endtask

    function automatic logic [7:0] dev(input logic rw);
        return {6'b000111, addr_sel, rw};
    endfunction

    task automatic wr_bytes(input logic [7:0] ptr, input logic [31:0] data,
                            input int n, output int acks);
        logic a;
        acks = 0;
        bus_start();
        send_byte(dev(1'b0), a); acks += int'(a);
        send_byte(ptr, a);       acks += int'(a);
        for (int i = 0; i < n; i++) begin
            send_byte(data[8*(n-1-i) +: 8], a);
            acks += int'(a);
        end
        bus_stop();
    endtask

    task automatic rd_bytes(input logic [7:0] ptr, input int n, output logic [31:0] got);
        logic a;
        logic [7:0] b;
        got = '0;
        bus_start();
        send_byte(dev(1'b0), a);
        send_byte(ptr, a);
        bus_start();
        send_byte(dev(1'b1), a);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            got = {got[23:0], b};
        end
        bus_stop();
    endtask

    task automatic probe(input logic [7:0] devb, output logic ack);
        bus_start();
        send_byte(devb, ack);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R2 actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int acks;
        logic [31:0] got;
        logic a;

        tick(5);
        rst = 1'b0;
        tick(5);

        // R9: reset state at the ports and in the registers
        check("R9 sda released", {31'd0, sda_pull_low}, 32'd0);
        check("R9 run_en", {31'd0, run_en}, 32'd0);
        rd_bytes(8'h10, 4, got);
        check("R9/R4 burst read 0x10-0x13", got, 32'h0000103F);
        rd_bytes(8'h14, 1, got);
        check("R9 data config", got, 32'h02);

        // table walk: write then read back
        for (int k = 0; k < NV; k++) begin
            wr_bytes(VECS[k].ptr, {24'd0, VECS[k].wval}, 1, acks);
            check($sformatf("R%0d acks at 0x%0h", VECS[k].req, VECS[k].ptr), acks, 3);
            rd_bytes(VECS[k].ptr, 1, got);
            check($sformatf("R%0d readback at 0x%0h", VECS[k].req, VECS[k].ptr),
                  got, {24'd0, VECS[k].exp});
        end

        // R3: burst write across 0x11-0x14
        wr_bytes(8'h11, 32'h01020304, 4, acks);
        check("R3 burst write acks", acks, 6);
        rd_bytes(8'h11, 4, got);
        check("R3 burst write landing", got, 32'h01020304);

        // R10: sample packing
        axis_data[0] = 12'h7FF;
        axis_data[1] = 12'h800;
        axis_data[2] = 12'hABC;
        tick(4);
        rd_bytes(8'h00, 4, got);
        check("R10 axis0/axis1 bytes", got, 32'hF07F0080);
        rd_bytes(8'h04, 2, got);
        check("R10 axis2 bytes", got, 32'h0000C0AB);

        // R12: pointer wrap
        rd_bytes(8'hFF, 2, got);
        check("R12 wrap 0xFF to 0x00", got, 32'h000000F0);

        // R6: self-test toggle and clear-on-read
        wr_bytes(8'h11, 32'h10, 1, acks);
        rd_bytes(8'h08, 1, got);
        check("R6 self-test active", got, 32'hAA);
        rd_bytes(8'h08, 1, got);
        check("R6 self-test restored", got, 32'h55);
        rd_bytes(8'h11, 1, got);
        check("R6 request bit cleared", got, 32'h00);

        // R7: protection while running
        wr_bytes(8'h12, 32'h11, 1, acks);
        wr_bytes(8'h10, 32'h03, 1, acks);
        wr_bytes(8'h10, 32'h83, 1, acks);
        check("R7 run_en set", {31'd0, run_en}, 32'd1);
        wr_bytes(8'h12, 32'h99, 1, acks);
        check("R7 protected write acked", acks, 3);
        rd_bytes(8'h12, 1, got);
        check("R7 protected byte kept", got, 32'h11);
        wr_bytes(8'h10, 32'hFC, 1, acks);
        rd_bytes(8'h10, 1, got);
        check("R7 ctrl1 low bits frozen", got, 32'h83);
        wr_bytes(8'h10, 32'h00, 1, acks);
        check("R7 run_en cleared", {31'd0, run_en}, 32'd0);
        wr_bytes(8'h12, 32'h99, 1, acks);
        rd_bytes(8'h12, 1, got);
        check("R7 write after stop running", got, 32'h99);

        // R1: strap-selected address
        addr_sel = 1'b1;
        probe(8'h1E, a);
        check("R1 strap-high address acked", {31'd0, a}, 32'd1);
        probe(8'h1C, a);
        check("R1 strap-low address refused", {31'd0, a}, 32'd0);
        bus_start();
        send_byte(8'h1C, a);
        send_byte(8'h13, a);
        send_byte(8'h44, a);
        bus_stop();
        check("R1 sda released after miss", {31'd0, sda_pull_low}, 32'd0);
        wr_bytes(8'h13, 32'h5B, 1, acks);
        check("R1 matched write acks", acks, 3);
        addr_sel = 1'b0;
        bus_start();
        send_byte(8'h1E, a);
        send_byte(8'h13, a);
        send_byte(8'h44, a);
        bus_stop();
        rd_bytes(8'h13, 1, got);
        check("R1 foreign write ignored", got, 32'h5B);

        // R11: drive timing observed over the whole run
        check("R11 drive moved with SCL high", drv_violations, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule